// File: doc/BRIEF.md
# Codec Host Serial Port

This block is the converter side of a synchronous, full-duplex serial link to a host processor. It divides a master clock down to the serial bit clock and drives that clock out. It also drives a transmit word sync. The host frames its own words with a sync line that the block follows. Each direction carries 16-bit words, most significant bit first, and both directions run at the same time.

A received word is either a register access or a DAC sample. Register writes and reads go out on a simple register strobe interface. The block keeps its own copy of the digital power-up flag, so that it can gate transmission. A DAC sample is presented on a held output together with a one-cycle strobe.

On transmit, each frame carries the ADC sample present at frame start. When a register read is waiting, the frame carries the read reply instead. The chip-select input enables the whole port. While chip select is low, the three port outputs float. No frame goes out until the host has written the power-up flag.

Top module: `codec_sport`

## Requirements
- R1: During reset, with chip select high, the serial clock, the transmit sync and the serial data out are all low, and `rx_valid` is low.
- R2: While chip select is high, the serial clock has a period of 2*HALF_DIV master cycles and stays high for HALF_DIV master cycles.
- R3: While chip select is low, the serial clock, transmit sync and serial data out are high impedance. Activity on the receive inputs then produces no received word. After chip select returns high, transmit frames start again without a new power-up write.
- R4: A receive word starts when the receive sync is sampled high on a falling serial clock edge. The next 16 falling edges sample `ser_in` most significant bit first. After the 16th bit, `rx_valid` pulses for one master cycle and `rx_word` holds the word.
- R5: If the receive sync is high on the same falling edge as the last bit of a word, the next word starts at the next falling edge, with no gap.
- R6: A transmit frame raises the transmit sync for exactly one serial clock period. Over the next 16 periods, `ser_out` carries the word most significant bit first. Data changes only on rising serial clock edges. Frame syncs repeat every FRAME_BITS serial clock periods.
- R7: No transmit sync is issued and `ser_out` stays low until the host writes a word with bit PWR_BIT = 1 to address PWR_ADDR. A later write with that bit = 0 stops transmission from the next frame boundary.
- R8: A received word with bit 15 = 1 is a register access. Bit 14 selects read (1) or write (0), bits 11:8 give the address and bits 7:0 give the write data. A write raises `reg_wr_en` for one cycle with that address and data, and produces no DAC strobe.
- R9: A received word with bit 15 = 0 is a DAC sample. One cycle after `rx_valid`, `dac_sample` becomes bits 14:0 sign-extended from bit 14, and `dac_strobe` pulses. `dac_sample` holds its value until the next sample word.
- R10: A read access raises `reg_rd_en` and performs no write. The first frame that starts after it carries {2'b11, 2'b00, address, `reg_rdata`}. Every other frame carries `adc_sample` as sampled at the start of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel | input | 1 | Port enable; low floats the port outputs |
| rx_sync | input | 1 | Receive word sync driven by the host |
| ser_in | input | 1 | Serial data from the host |
| ser_clk | output | 1 | Serial bit clock (tri-state) |
| tx_sync | output | 1 | Transmit word sync (tri-state) |
| ser_out | output | 1 | Serial data to the host (tri-state) |
| reg_wr_en | output | 1 | Register write strobe |
| reg_rd_en | output | 1 | Register read strobe |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | DATA_W | Register write data |
| reg_rdata | input | DATA_W | Register read data, sampled with `reg_rd_en` |
| adc_sample | input | WORD_W | ADC sample to transmit |
| dac_sample | output | WORD_W | Last DAC sample received, sign-extended |
| dac_strobe | output | 1 | One-cycle pulse on a new DAC sample |
| rx_word | output | WORD_W | Last complete received word |
| rx_valid | output | 1 | One-cycle pulse on a completed word |

## Verification
Several functions of this block can fall in the same cycle. The clearest pair is the completion of one received word and the sync that opens the next one: both are sampled on the same falling edge. The bench provokes this by sending two register writes back to back, with the sync of the second word driven during the last bit of the first. It judges the result in two ways: the write count must rise by two, and a later read of the first address must return its data. A second overlap lies in the duplex traffic. Read requests arrive while transmit frames are running, and the bench checks that the reply appears in exactly the first frame that starts after the request, with the ADC sample in the frame after.

// File: rtl/codec_sport_pkg.sv
package codec_sport_pkg;

   // Kind of a received word, decoded from its top two bits
   typedef enum logic [1:0] {
      KIND_SAMPLE = 2'd0,
      KIND_WRITE  = 2'd1,
      KIND_READ   = 2'd2
   } word_kind_e;

   // Counter width that is never zero
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/codec_sport_clkgen.sv
module codec_sport_clkgen
   import codec_sport_pkg::*;
#(
   parameter int unsigned HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic sclk,
   output logic rise_ev,
   output logic fall_ev
);

   logic tick;

   generate
      if (HALF_DIV == 0) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (HALF_DIV == 1) begin : g_nodiv
         assign tick = en;
      end else begin : g_div
         localparam int unsigned CW = cnt_width(HALF_DIV);
         localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt <= '0;
            else if (!en)         cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end
         assign tick = en && (cnt == LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sclk <= 1'b0;
      else if (!en)  sclk <= 1'b0;
      else if (tick) sclk <= ~sclk;
   end

   assign rise_ev = tick && !sclk;
   assign fall_ev = tick && sclk;

   // R3
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !sclk);

   // R2
   sclk_rise_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> $past(en));

endmodule

// File: rtl/codec_sport_rx.sv
module codec_sport_rx
   import codec_sport_pkg::*;
#(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              fall_ev,
   input  logic              sdi,
   input  logic              sync,
   output logic [WORD_W-1:0] word,
   output logic              valid
);

   localparam int unsigned CW = cnt_width(WORD_W);
   localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

   logic              busy;
   logic [CW-1:0]     cnt;
   logic [WORD_W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt   <= '0;
         sh    <= '0;
         word  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (!en) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else if (fall_ev) begin
            if (!busy) begin
               busy <= sync;
               cnt  <= '0;
            end else begin
               sh <= {sh[WORD_W-2:0], sdi};
               if (cnt == LAST) begin
                  word  <= {sh[WORD_W-2:0], sdi};
                  valid <= 1'b1;
                  busy  <= sync;   // back-to-back framing
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   end

   // R4
   rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   // R3
   rx_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !valid);

endmodule

// File: rtl/codec_sport_tx.sv
module codec_sport_tx
   import codec_sport_pkg::*;
#(
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned FRAME_BITS = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              rise_ev,
   input  logic              pwr_on,
   input  logic [WORD_W-1:0] load_word,
   output logic              load,
   output logic              sdo,
   output logic              sync
);

   localparam int unsigned SW = cnt_width(FRAME_BITS);
   localparam logic [SW-1:0] LAST = SW'(FRAME_BITS - 1);
   localparam logic [SW-1:0] LAST_DATA = SW'(WORD_W);

   generate
      if (FRAME_BITS < WORD_W + 1) begin : g_bad_frame
         $error("FRAME_BITS must hold the sync slot and a full word");
      end
   endgenerate

   logic [SW-1:0]     slot;
   logic [SW-1:0]     nslot;
   logic              frame_on;
   logic [WORD_W-1:0] shreg;

   assign nslot = (slot == LAST) ? '0 : slot + 1'b1;
   assign load  = en && rise_ev && (nslot == '0) && pwr_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot     <= LAST;
         frame_on <= 1'b0;
         shreg    <= '0;
         sdo      <= 1'b0;
         sync     <= 1'b0;
      end else if (!en) begin
         slot     <= LAST;
         frame_on <= 1'b0;
         sdo      <= 1'b0;
         sync     <= 1'b0;
      end else if (rise_ev) begin
         slot <= nslot;
         if (nslot == '0) begin
            frame_on <= pwr_on;
            sync     <= pwr_on;
            sdo      <= 1'b0;
            if (pwr_on) shreg <= load_word;
         end else begin
            sync <= 1'b0;
            if (frame_on && nslot <= LAST_DATA) begin
               sdo   <= shreg[WORD_W-1];
               shreg <= {shreg[WORD_W-2:0], 1'b0};
            end else begin
               sdo <= 1'b0;
            end
         end
      end
   end

   // R6
   sdo_rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && !$past(rise_ev)) |-> $stable(sdo));

   // R7
   sync_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync) |-> $past(pwr_on));

endmodule

// File: rtl/codec_sport.sv
module codec_sport
   import codec_sport_pkg::*;
#(
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned HALF_DIV   = 4,
   parameter int unsigned FRAME_BITS = 18,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned PWR_ADDR   = 1,
   parameter int unsigned PWR_BIT    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_sel,
   input  logic              rx_sync,
   input  logic              ser_in,
   output logic              ser_clk,
   output logic              tx_sync,
   output logic              ser_out,
   output logic              reg_wr_en,
   output logic              reg_rd_en,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] reg_rdata,
   input  logic [WORD_W-1:0] adc_sample,
   output logic [WORD_W-1:0] dac_sample,
   output logic              dac_strobe,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid
);

   localparam int PAD_W = int'(WORD_W) - 2 - int'(ADDR_W) - int'(DATA_W);

   generate
      if (PAD_W < 0) begin : g_bad_fields
         $error("address and data fields do not fit in a word");
      end
      if (PWR_BIT >= DATA_W) begin : g_bad_pwr_bit
         $error("PWR_BIT lies outside the data field");
      end
      if (PWR_ADDR >= (1 << ADDR_W)) begin : g_bad_pwr_addr
         $error("PWR_ADDR lies outside the address range");
      end
   endgenerate

   logic sclk_int, rise_ev, fall_ev;
   logic tx_sync_int, ser_out_int, tx_load;
   logic pwr_on;
   logic pending;
   logic [WORD_W-1:0] reply_word, reply_next, tx_word;
   word_kind_e kind;

   codec_sport_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .en(chip_sel),
      .sclk(sclk_int), .rise_ev(rise_ev), .fall_ev(fall_ev)
   );

   codec_sport_rx #(.WORD_W(WORD_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .en(chip_sel), .fall_ev(fall_ev),
      .sdi(ser_in), .sync(rx_sync), .word(rx_word), .valid(rx_valid)
   );

   codec_sport_tx #(.WORD_W(WORD_W), .FRAME_BITS(FRAME_BITS)) u_tx (
      .clk(clk), .rst_n(rst_n), .en(chip_sel), .rise_ev(rise_ev),
      .pwr_on(pwr_on), .load_word(tx_word), .load(tx_load),
      .sdo(ser_out_int), .sync(tx_sync_int)
   );

   // Port pins float while the chip is deselected
   assign ser_clk = chip_sel ? sclk_int    : 1'bz;
   assign tx_sync = chip_sel ? tx_sync_int : 1'bz;
   assign ser_out = chip_sel ? ser_out_int : 1'bz;

   // Received word routing
   always_comb begin
      if (!rx_word[WORD_W-1])     kind = KIND_SAMPLE;
      else if (rx_word[WORD_W-2]) kind = KIND_READ;
      else                        kind = KIND_WRITE;
   end

   assign reg_wr_en = rx_valid && (kind == KIND_WRITE);
   assign reg_rd_en = rx_valid && (kind == KIND_READ);
   assign reg_addr  = rx_word[ADDR_W+DATA_W-1:DATA_W];
   assign reg_wdata = rx_word[DATA_W-1:0];

   // Local copy of the digital power-up flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwr_on <= 1'b0;
      else if (reg_wr_en && reg_addr == ADDR_W'(PWR_ADDR)) pwr_on <= reg_wdata[PWR_BIT];
   end

   // DAC sample hold
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_sample <= '0;
         dac_strobe <= 1'b0;
      end else begin
         dac_strobe <= rx_valid && (kind == KIND_SAMPLE);
         if (rx_valid && kind == KIND_SAMPLE)
            dac_sample <= {rx_word[WORD_W-2], rx_word[WORD_W-2:0]};
      end
   end

   // Read reply word
   generate
      if (PAD_W > 0) begin : g_pad
         assign reply_next = {2'b11, {PAD_W{1'b0}}, reg_addr, reg_rdata};
      end else begin : g_nopad
         assign reply_next = {2'b11, reg_addr, reg_rdata};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending    <= 1'b0;
         reply_word <= '0;
      end else if (reg_rd_en) begin
         pending    <= 1'b1;
         reply_word <= reply_next;
      end else if (tx_load) begin
         pending    <= 1'b0;
      end
   end

   assign tx_word = pending ? reply_word : adc_sample;

   // R10
   reply_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pending) |-> $past(tx_load));

endmodule

// File: tb/test_codec_sport.sv
module test_codec_sport;
   import codec_sport_pkg::*;

   localparam int W = 16, HALF = 2, FB = 18, AW = 4, DW = 8, PA = 1, PB = 0;

   logic clk = 1'b0, rst_n = 1'b0, chip_sel = 1'b1, rx_sync = 1'b0, ser_in = 1'b0;
   wire  ser_clk, tx_sync, ser_out;
   logic reg_wr_en, reg_rd_en, dac_strobe, rx_valid;
   logic [AW-1:0] reg_addr;
   logic [DW-1:0] reg_wdata, reg_rdata;
   logic [W-1:0]  adc_sample = 16'hA5C3, dac_sample, rx_word;

   int checks = 0, errors = 0, rx_cnt = 0, dac_cnt = 0, wr_cnt = 0;
   logic [AW-1:0] last_wa = '0;
   logic [DW-1:0] last_wd = '0;
   logic [DW-1:0] model [16];
   logic [DW-1:0] exp_reg [16];

   always #5 clk = ~clk;

   codec_sport #(.WORD_W(W), .HALF_DIV(HALF), .FRAME_BITS(FB), .ADDR_W(AW),
                 .DATA_W(DW), .PWR_ADDR(PA), .PWR_BIT(PB)) i_codec_sport (
      .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .rx_sync(rx_sync), .ser_in(ser_in),
      .ser_clk(ser_clk), .tx_sync(tx_sync), .ser_out(ser_out),
      .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adc_sample(adc_sample),
      .dac_sample(dac_sample), .dac_strobe(dac_strobe), .rx_word(rx_word), .rx_valid(rx_valid)
   );

   // External register file seen by the block
   assign reg_rdata = model[reg_addr];
   always @(posedge clk) begin
      if (rx_valid) rx_cnt++;
      if (dac_strobe) dac_cnt++;
      if (reg_wr_en) begin
         model[reg_addr] <= reg_wdata;
         wr_cnt++;
         last_wa <= reg_addr;
         last_wd <= reg_wdata;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic host_sync_slot();
      @(posedge ser_clk); #1;
      rx_sync = 1'b1; ser_in = 1'b0;
   endtask

   task automatic host_bits(input logic [W-1:0] w, input bit sync_last);
      for (int b = W - 1; b >= 0; b--) begin
         @(posedge ser_clk); #1;
         ser_in  = w[b];
         rx_sync = (b == 0) && sync_last;
      end
   endtask

   task automatic settle();
      @(negedge ser_clk); #25;
      rx_sync = 1'b0; ser_in = 1'b0;
   endtask

   task automatic host_send(input logic [W-1:0] w);
      host_sync_slot();
      host_bits(w, 1'b0);
      settle();
   endtask

   task automatic host_pair(input logic [W-1:0] a, input logic [W-1:0] b);
      host_sync_slot();
      host_bits(a, 1'b1);
      host_bits(b, 1'b0);
      settle();
   endtask

   task automatic capture(output logic [W-1:0] w, output bit ok);
      ok = 1'b0; w = '0;
      for (int i = 0; i < 3 * FB && !ok; i++) begin
         @(negedge ser_clk); #1;
         if (tx_sync === 1'b1) ok = 1'b1;
      end
      if (ok) begin
         for (int b = W - 1; b >= 0; b--) begin
            @(negedge ser_clk); #1;
            if (b == W - 1) chk("R6 sync lasts one bit period", {31'd0, tx_sync}, 32'd0);
            w[b] = ser_out;
         end
      end
   endtask

   function automatic logic [W-1:0] wr_word(input int a, input logic [DW-1:0] d);
      return {2'b10, 2'b00, 4'(a), d};
   endfunction

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] w, v, w2;
      bit ok;
      time t0, t1, t2;
      int base, dbase, rbase, n_sync, n_data;

      repeat (3) @(posedge clk); #1;
      // R1
      chk("R1 serial clock low in reset", {31'd0, ser_clk}, 32'd0);
      chk("R1 transmit sync low in reset", {31'd0, tx_sync}, 32'd0);
      chk("R1 serial data low in reset", {31'd0, ser_out}, 32'd0);
      chk("R1 no receive strobe in reset", {31'd0, rx_valid}, 32'd0);
      rst_n = 1'b1;

      // R2
      @(posedge ser_clk); t0 = $time;
      @(negedge ser_clk); t1 = $time;
      @(posedge ser_clk); t2 = $time;
      chk("R2 serial clock high time", 32'(t1 - t0), 32'(HALF * 10));
      chk("R2 serial clock period", 32'(t2 - t0), 32'(2 * HALF * 10));

      // R7 nothing sent before power-up
      n_sync = 0; n_data = 0;
      repeat (3 * FB) begin
         @(negedge ser_clk); #1;
         if (tx_sync === 1'b1) n_sync++;
         if (ser_out !== 1'b0) n_data++;
      end
      chk("R7 no sync before power-up", 32'(n_sync), 32'd0);
      chk("R7 data low before power-up", 32'(n_data), 32'd0);

      // R8 / R4 write sweep over all addresses except the power register
      base = wr_cnt; dbase = dac_cnt;
      for (int a = 0; a < 16; a++) begin
         if (a != PA) begin
            logic [DW-1:0] d;
            rbase = rx_cnt;
            d = DW'((a * 37 + 11) & 8'hFF);
            host_send(wr_word(a, d));
            exp_reg[a] = d;
            chk("R4 one receive strobe per word", 32'(rx_cnt - rbase), 32'd1);
            chk("R4 assembled word", 32'(rx_word), 32'(wr_word(a, d)));
            chk("R8 write address", 32'(last_wa), 32'(a));
            chk("R8 write data", 32'(last_wd), 32'(d));
         end
      end
      chk("R8 write count", 32'(wr_cnt - base), 32'd15);
      chk("R8 writes give no DAC strobe", 32'(dac_cnt - dbase), 32'd0);

      // R9 DAC sample sweep, sign extension from bit 14
      dbase = dac_cnt; base = wr_cnt;
      for (int k = 0; k < 8; k++) begin
         case (k)
            0: v = 16'h0000;
            1: v = 16'h7FFF;
            2: v = 16'h4000;
            3: v = 16'h3FFF;
            default: v = 16'((k * 16'h1357 + 16'h0101) & 16'h7FFF);
         endcase
         host_send(v);
         chk("R9 DAC sample sign-extended", 32'(dac_sample), 32'({v[14], v[14:0]}));
         chk("R9 one DAC strobe per sample", 32'(dac_cnt - dbase), 32'(k + 1));
      end
      chk("R9 samples cause no register write", 32'(wr_cnt - base), 32'd0);
      host_send(wr_word(3, 8'h77));
      exp_reg[3] = 8'h77;
      chk("R9 DAC sample held across a register word", 32'(dac_sample), 32'({v[14], v[14:0]}));

      // R5 back-to-back words
      base = wr_cnt; rbase = rx_cnt;
      host_pair(wr_word(4, 8'h5A), wr_word(6, 8'hC3));
      exp_reg[4] = 8'h5A; exp_reg[6] = 8'hC3;
      chk("R5 both back-to-back words received", 32'(rx_cnt - rbase), 32'd2);
      chk("R5 both back-to-back writes", 32'(wr_cnt - base), 32'd2);
      chk("R5 second word address", 32'(last_wa), 32'd6);

      // R7 power up
      host_send(wr_word(PA, 8'h01));
      capture(w, ok);
      chk("R7 frames start after power-up", {31'd0, ok}, 32'd1);

      // R6 / R10 ADC sweep
      for (int k = 0; k < 6; k++) begin
         adc_sample = 16'((k * 16'h3B29) ^ 16'h8001);
         capture(w, ok);
         chk("R6 frame sync seen", {31'd0, ok}, 32'd1);
         chk("R10 frame carries ADC sample", 32'(w), 32'(adc_sample));
      end

      // R6 frame spacing
      n_sync = 0;
      for (int i = 0; i < 3 * FB && n_sync == 0; i++) begin
         @(negedge ser_clk); #1;
         if (tx_sync === 1'b1) n_sync = 1;
      end
      n_data = 0;
      for (int i = 0; i < 3 * FB && n_sync == 1; i++) begin
         @(negedge ser_clk); #1;
         n_data++;
         if (tx_sync === 1'b1) n_sync = 2;
      end
      chk("R6 frame period in bit periods", 32'(n_data), 32'(FB));

      // R10 read replies, including the first word of the back-to-back pair (R5)
      base = wr_cnt;
      for (int j = 0; j < 4; j++) begin
         int a;
         a = (j == 0) ? 0 : (j == 1) ? 4 : (j == 2) ? 15 : 7;
         host_send({2'b11, 2'b00, 4'(a), 8'h00});
         capture(w, ok);
         chk((a == 4) ? "R5 first back-to-back write read back" : "R10 read reply frame",
             32'(w), 32'({2'b11, 2'b00, 4'(a), exp_reg[a]}));
         capture(w2, ok);
         chk("R10 following frame returns to ADC sample", 32'(w2), 32'(adc_sample));
      end
      chk("R10 reads perform no write", 32'(wr_cnt - base), 32'd0);

      // R3 chip select low
      rbase = rx_cnt;
      chip_sel = 1'b0;
      #7;
      chk("R3 serial clock floats", {31'd0, ser_clk === 1'bz}, 32'd1);
      chk("R3 transmit sync floats", {31'd0, tx_sync === 1'bz}, 32'd1);
      chk("R3 serial data floats", {31'd0, ser_out === 1'bz}, 32'd1);
      rx_sync = 1'b1;
      repeat (40) begin
         #20;
         ser_in  = ~ser_in;
         rx_sync = 1'b0;
      end
      ser_in = 1'b0;
      #20;
      chk("R3 no word received while deselected", 32'(rx_cnt - rbase), 32'd0);
      chip_sel = 1'b1;
      adc_sample = 16'h1E2D;
      capture(w, ok);
      chk("R3 frames resume after reselect", {31'd0, ok}, 32'd1);
      chk("R3 resumed frame content", 32'(w), 32'(adc_sample));

      // R7 power down
      host_send(wr_word(PA, 8'h00));
      n_sync = 0; n_data = 0;
      for (int i = 0; i < 3 * FB; i++) begin
         @(negedge ser_clk); #1;
         if (tx_sync === 1'b1) n_sync++;
         if (i >= FB && ser_out !== 1'b0) n_data++;
      end
      chk("R7 no sync after power-down", 32'(n_sync), 32'd0);
      chk("R7 data low after power-down", 32'(n_data), 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule